// File: doc/BRIEF.md
# Per-Timeslot Signaling Capture Buffer

This block watches a serial signaling stream that runs beside a PCM data stream. The stream is cut into fixed 8-bit time slots. A frame-sync pulse marks the first bit of slot 0. The block counts bit positions, works out which slot each bit belongs to, and keeps the last few bits of the current slot. When a slot's final bit arrives, it writes that slot's 4-bit signaling nibble into the buffer entry that has the same index as the slot.

A processor port can read or overwrite any entry at any time, while the stream keeps refreshing the entries once per frame. Reads are combinational. The upper half of every byte-wide entry always reads as zero. If a processor write and a stream write hit the same entry in the same cycle, the processor write wins. The bit clock is a single-cycle enable `bitEn` in the system clock domain. Each asserted cycle carries one stream bit.

Top module: `sigcap_buffer`

## Requirements
- R1: After reset every one of the 32 entries reads 0x00.
- R2: A cycle with `bitEn` and `frameSync` both high carries bit 0 of slot 0. Each later `bitEn` cycle carries the next bit, so slot N occupies stream bits 8N to 8N+7.
- R3: Entry N takes bits 4..7 of slot N, with bit 4 (the earlier bit) as entry bit 3 and bit 7 as entry bit 0. The new value is readable from the clock edge that samples bit 7 of slot N onward.
- R4: Entry bits 7..4 always read zero, even after a processor write of ones there.
- R5: Until the first `frameSync` has been seen after reset, stream bits write no entry.
- R6: A processor write with `cpuWrEn` high stores `cpuWrData[3:0]` into entry `cpuAddr` at the next clock edge. `cpuRdData` shows the entry selected by `cpuAddr` combinationally.
- R7: When a processor write and a stream write target the same entry in the same cycle, the entry holds the processor's value. When they target different entries, both writes take effect.
- R8: Cycles with `bitEn` low neither advance the bit position nor consume `sigBit`.
- R9: A `frameSync` that arrives in the middle of a frame restarts the count at bit 0 of slot 0.
- R10: Without a new `frameSync`, the count wraps after bit 7 of slot 31 to bit 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bitEn | input | 1 | One stream bit is present this cycle |
| frameSync | input | 1 | With bitEn, marks bit 0 of slot 0 |
| sigBit | input | 1 | Serial signaling data bit |
| cpuWrEn | input | 1 | Processor write strobe |
| cpuAddr | input | 5 | Processor entry index for read and write |
| cpuWrData | input | 8 | Processor write data (low 4 bits stored) |
| cpuRdData | output | 8 | Entry at cpuAddr, upper 4 bits zero |

## Verification
The assertions check the following on every cycle:
- the bit position holds while `bitEn` is low;
- a sync bit restarts the count;
- the count wraps after the last bit of the frame;
- a stream commit lands in the entry it targets unless the processor writes that same entry;
- a processor write always lands.

Only the bench's scenarios can show the rest. These are the bit order inside each captured nibble, the suppression of writes before the first sync, and realignment after a mid-frame sync. They also include the combined effect of collisions on whole-buffer contents, which the bench checks by sweeping every entry against an arithmetic model of the stream.

// File: rtl/sigcap_pkg.sv
package sigcap_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic shiftEn;   // accept sigBit into the history register
    logic commitEn;  // last bit of a slot: write nibble into the buffer
  } sigStrobe_t;

endpackage

// File: rtl/sigcap_ctrl.sv
module sigcap_ctrl
  import sigcap_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS,
  localparam int CNT_W      = $clog2(FRAME_BITS),
  localparam int OFF_W      = $clog2(SLOT_BITS),
  localparam int IDX_W      = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitEn,
  input  logic             frameSync,
  output sigStrobe_t       strobe,
  output logic [IDX_W-1:0] slotIdx
);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] curPos;
  logic [CNT_W-1:0] nextPos;
  logic             locked;
  logic             lastBit;

  // position of the bit present this cycle; sync forces position zero
  always_comb begin
    curPos  = frameSync ? '0 : bitCnt;
    nextPos = (curPos == CNT_W'(FRAME_BITS - 1)) ? '0 : curPos + 1'b1;
    lastBit = (curPos[OFF_W-1:0] == OFF_W'(SLOT_BITS - 1));
  end

  assign slotIdx         = curPos[CNT_W-1:OFF_W];
  assign strobe.shiftEn  = bitEn;
  assign strobe.commitEn = bitEn && (locked || frameSync) && lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      locked <= 1'b0;
    end else if (bitEn) begin
      bitCnt <= nextPos;
      locked <= locked || frameSync;
    end
  end

  // R8: idle cycles leave the position untouched
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> $stable(bitCnt));

  // R9: a sync bit makes the following bit position one
  p_sync_realign_r9: assert property (@(posedge clk) disable iff (rst)
    (bitEn && frameSync) |=> (bitCnt == CNT_W'(1)));

  // R10: last bit of the frame wraps to zero
  p_frame_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (bitEn && !frameSync && bitCnt == CNT_W'(FRAME_BITS - 1)) |=> (bitCnt == '0));

endmodule

// File: rtl/sigcap_dpath.sv
module sigcap_dpath
  import sigcap_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SIG_BITS  = 4,
  parameter int ENTRY_W   = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int HIST_W   = SIG_BITS - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  sigStrobe_t         strobe,
  input  logic [IDX_W-1:0]   slotIdx,
  input  logic               sigBit,
  input  logic               cpuWrEn,
  input  logic [IDX_W-1:0]   cpuAddr,
  input  logic [ENTRY_W-1:0] cpuWrData,
  output logic [ENTRY_W-1:0] cpuRdData
);

  logic [HIST_W-1:0]   shiftReg;
  logic [SIG_BITS-1:0] nibble;
  logic [SIG_BITS-1:0] entries [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cpuSel;
  logic [NUM_SLOTS-1:0] streamSel;
  logic                 unusedHighBits;
  logic                 armed;

  assign unusedHighBits = ^cpuWrData[ENTRY_W-1:SIG_BITS];

  // earlier bits sit higher; the current bit closes the nibble
  assign nibble = {shiftReg, sigBit};

  always_ff @(posedge clk) begin
    if (rst)                 shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= nibble[HIST_W-1:0];
  end

  // per-entry write selects
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign cpuSel[i]    = cpuWrEn && (cpuAddr == IDX_W'(i));
    assign streamSel[i] = strobe.commitEn && (slotIdx == IDX_W'(i));
  end

  // processor write has priority over the stream on the same entry
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) entries[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (cpuSel[i])         entries[i] <= cpuWrData[SIG_BITS-1:0];
        else if (streamSel[i]) entries[i] <= nibble;
      end
    end
  end

  assign cpuRdData = {{(ENTRY_W - SIG_BITS){1'b0}}, entries[cpuAddr]};

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7: a processor write always lands
  p_cpu_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cpuWrEn)) |->
      (entries[$past(cpuAddr)] == $past(cpuWrData[SIG_BITS-1:0])));

  // R3: a stream commit lands unless the processor took that entry
  p_stream_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(strobe.commitEn) &&
     !($past(cpuWrEn) && ($past(cpuAddr) == $past(slotIdx)))) |->
      (entries[$past(slotIdx)] == $past(nibble)));

endmodule

// File: rtl/sigcap_buffer.sv
module sigcap_buffer
  import sigcap_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  parameter int SIG_BITS  = 4,
  parameter int ENTRY_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bitEn,
  input  logic                         frameSync,
  input  logic                         sigBit,
  input  logic                         cpuWrEn,
  input  logic [$clog2(NUM_SLOTS)-1:0] cpuAddr,
  input  logic [ENTRY_W-1:0]           cpuWrData,
  output logic [ENTRY_W-1:0]           cpuRdData
);

  localparam int IDX_W = $clog2(NUM_SLOTS);

  sigStrobe_t       strobe;
  logic [IDX_W-1:0] slotIdx;

  sigcap_ctrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_BITS(SLOT_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitEn    (bitEn),
    .frameSync(frameSync),
    .strobe   (strobe),
    .slotIdx  (slotIdx)
  );

  sigcap_dpath #(
    .NUM_SLOTS(NUM_SLOTS),
    .SIG_BITS (SIG_BITS),
    .ENTRY_W  (ENTRY_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .slotIdx  (slotIdx),
    .sigBit   (sigBit),
    .cpuWrEn  (cpuWrEn),
    .cpuAddr  (cpuAddr),
    .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData)
  );

endmodule

// File: tb/sigcap_buffer_bench.sv
`timescale 1ns/1ps
module sigcap_buffer_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       bitEn;
  logic       frameSync;
  logic       sigBit;
  logic       cpuWrEn;
  logic [4:0] cpuAddr;
  logic [7:0] cpuWrData;
  logic [7:0] cpuRdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] expMem [32];
  logic modelLocked;

  always #4 clk = ~clk;

  sigcap_buffer u_sigcap_buffer (
    .clk(clk), .rst(rst), .bitEn(bitEn), .frameSync(frameSync), .sigBit(sigBit),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData)
  );

  function automatic logic [7:0] slotVal(input int seed, input int s);
    return 8'((s * 29 + seed * 53 + 17) & 255);
  endfunction

  task automatic readCheck(input int a, input logic [7:0] expv, input string tag);
    cpuAddr = 5'(a);
    #1;
    nChecks++;
    if (cpuRdData !== expv) begin
      nFails++;
      $display("FAIL %s entry %0d: got %h expected %h", tag, a, cpuRdData, expv);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int i = 0; i < 32; i++) readCheck(i, {4'h0, expMem[i]}, tag);
  endtask

  // one stream bit; inputs change only at falling edges
  task automatic pushBit(input logic b, input logic fs, input int gap,
                         input logic cw, input int ca, input logic [7:0] cd);
    @(negedge clk);
    sigBit = b; frameSync = fs; bitEn = 1'b1;
    cpuWrEn = cw; cpuAddr = 5'(ca); cpuWrData = cd;
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0; cpuWrEn = 1'b0;
    sigBit = ~b;  // junk on idle cycles must be ignored (R8)
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic sendFrame(input int seed, input logic withSync, input int nSlots,
                           input int colSlot, input int colAddr, input logic [7:0] colData);
    for (int s = 0; s < nSlots; s++) begin
      logic [7:0] v;
      v = slotVal(seed, s);
      for (int b = 7; b >= 0; b--) begin
        pushBit(v[b], withSync && s == 0 && b == 7, (s + b) % 3,
                (s == colSlot) && b == 0, colAddr, colData);
      end
      if (withSync) modelLocked = 1'b1;
      if (modelLocked) expMem[s] = v[3:0];
      if (s == colSlot) expMem[colAddr] = colData[3:0];
    end
  endtask

  task automatic cpuWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = 5'(a); cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
    expMem[a] = d[3:0];
  endtask

  initial begin
    #800000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1; bitEn = 1'b0; frameSync = 1'b0; sigBit = 1'b0;
    cpuWrEn = 1'b0; cpuAddr = '0; cpuWrData = '0;
    modelLocked = 1'b0;
    for (int i = 0; i < 32; i++) expMem[i] = 4'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset contents
    checkAll("R1 reset");

    // R5: a whole frame before any sync writes nothing
    sendFrame(1, 1'b0, 32, -1, 0, 8'h00);
    checkAll("R5 unlocked");

    // R2 R3: first synced frame, then a second with new values
    sendFrame(2, 1'b1, 32, -1, 0, 8'h00);
    checkAll("R3 frame2");
    sendFrame(3, 1'b1, 32, -1, 0, 8'h00);
    checkAll("R2 frame3");

    // R10: next frame has no sync and relies on wrap
    sendFrame(4, 1'b0, 32, -1, 0, 8'h00);
    checkAll("R10 wrap");

    // R4 R6: processor writes with junk in upper bits
    cpuWrite(5, 8'hFF);
    readCheck(5, 8'h0F, "R4 upper");
    for (int i = 0; i < 32; i++) cpuWrite(i, 8'(((i * 7 + 3) & 15) | 8'hA0));
    checkAll("R6 cpu sweep");

    // R7: same-entry collision on slot 3, then different-entry on slot 4
    sendFrame(5, 1'b1, 4, 3, 3, 8'h5A);
    sendFrame(6, 1'b1, 5, 4, 30, 8'h36);
    checkAll("R7 collision");

    // R9: full frame, partial frame, then mid-frame resync
    sendFrame(7, 1'b1, 32, -1, 0, 8'h00);
    sendFrame(8, 1'b0, 2, -1, 0, 8'h00);
    for (int b = 0; b < 4; b++) pushBit(b[0], 1'b0, 0, 1'b0, 0, 8'h00);
    sendFrame(9, 1'b1, 3, -1, 0, 8'h00);
    checkAll("R9 realign");

    // R8: idle cycles with wiggling data change nothing
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      sigBit = k[0];
    end
    checkAll("R8 idle");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule